// File: doc/BRIEF.md
# Halt and Wake-up Sequencer

This block manages the low-power state of a small processor core. A one-cycle halt strobe from the core moves it into the halted state. While halted it removes the system clock enable and raises a halt output, which can switch off external program memory. Memory, registers and I/O keep their contents because the core stops rather than resets. The block's own clock runs freely, so it keeps watching for wake events while the core's clock is gated.

Four events end the halt. External reset gives a full initialisation. A watchdog overflow ends in a warm-reset pulse. An interrupt request ends in either a resume pulse or a vector pulse. A falling edge on an enabled bit of an 8-bit input port ends in a resume pulse. Every wake is followed by a fixed dummy period, `DUMMY_CYCLES` (1024 by default), before the core runs again. The interrupt path decides between continuing at the next instruction and taking a regular interrupt response, using the interrupt-enable and stack-full status supplied by the core. The vector case costs one extra acknowledge cycle. An interrupt whose request flag was already set when halt was entered is barred from waking the device.

The states are RUN, HALT, DUMMY and ACK. The transitions are:
- RUN to HALT on the halt strobe.
- HALT to DUMMY on any wake.
- DUMMY to RUN at the end of the delay for a resume or warm wake.
- DUMMY to ACK at the end of the delay for a vector wake.
- ACK to RUN after one cycle.

Top module: `halt_wake_seq`

## Requirements
- R1: A `halt_req` high while running makes `halt_out` and `halted` high and `sys_clk_en` low from the next cycle.
- R2: With no wake event the block stays halted, and a `halt_req` seen while halted has no effect.
- R3: A high-to-low change on a port bit whose `port_wake_mask` bit is 1 wakes the block. `halt_out` falls three clock edges after the change, because of the two synchroniser stages. Rising edges and edges on unmasked bits do not wake it.
- R4: After a wake, `halt_out` is low while `halted` stays high and `sys_clk_en` stays low for exactly `DUMMY_CYCLES` cycles, or one more in the vector case.
- R5: A port-edge wake ends with `resume_pulse` high for one cycle, in the same cycle that `sys_clk_en` returns to 1.
- R6: An interrupt wake whose request has its `irq_en` bit at 0, or that arrives while `stack_full` is 1, ends with `resume_pulse`.
- R7: An interrupt wake from a request with `irq_en` set while `stack_full` is 0 passes through one acknowledge cycle after the dummy period and ends with `vector_pulse`.
- R8: An `irq_req` bit that is already 1 at the cycle of halt entry cannot wake the block. Other request bits still can.
- R9: `wdt_ovf` high while halted wakes the block one edge later and ends with `warm_rst_pulse` instead of `resume_pulse`.
- R10: When wake sources are presented in the same cycle, the watchdog takes precedence over interrupts, and interrupts take precedence over port edges.
- R11: `rst_n` low returns the block at once to running, with `sys_clk_en` high, all status low and no pending pulse.
- R12: `resume_pulse`, `vector_pulse` and `warm_rst_pulse` are never high together, and each lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock, kept active during halt |
| rst_n | input | 1 | Asynchronous active-low external reset |
| halt_req | input | 1 | One-cycle halt strobe from the core |
| port_in | input | PORT_W | Raw input port, asynchronous |
| port_wake_mask | input | PORT_W | 1 = a falling edge on this bit may wake the block |
| irq_req | input | NIRQ | Interrupt request flags |
| irq_en | input | NIRQ | Per-source interrupt enables |
| stack_full | input | 1 | Return stack has no free entry |
| wdt_ovf | input | 1 | Watchdog overflow |
| sys_clk_en | output | 1 | Core clock enable; low while halted or waking |
| halt_out | output | 1 | High only in the HALT state |
| halted | output | 1 | High from halt entry until the core resumes |
| resume_pulse | output | 1 | Continue at the next instruction |
| vector_pulse | output | 1 | Take the interrupt response |
| warm_rst_pulse | output | 1 | Warm reset of the program counter and stack pointer |

## Verification
A wrong state or wake-kind register shows at the ports as the wrong pulse, or as a dummy period whose length differs from `DUMMY_CYCLES` (plus one for a vector). Both are visible about a thousand cycles after the wake. A faulty pending-request capture, a wrong synchroniser depth or a wrong source priority shows sooner, within three edges of the stimulus: the fall of `halt_out` either arrives early, arrives late, or does not arrive at all.

// File: rtl/halt_pkg.sv
package halt_pkg;
    typedef enum logic [1:0] {
        ST_RUN,
        ST_HALT,
        ST_DUMMY,
        ST_ACK
    } seq_state_t;

    typedef enum logic [1:0] {
        WK_PORT,
        WK_IRQ_RESUME,
        WK_IRQ_VECTOR,
        WK_WDT
    } wake_kind_t;
endpackage

// File: rtl/halt_port_edge.sv
// Two-stage synchroniser plus previous-value compare on a masked port.
module halt_port_edge #(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] port_in,
    input  logic [PORT_W-1:0] mask,
    output logic              fall_any
);
    logic [PORT_W-1:0] sync1_q, sync2_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q <= '0;
            sync2_q <= '0;
            prev_q  <= '0;
        end else begin
            sync1_q <= port_in;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
        end
    end

    assign fall_any = |(prev_q & ~sync2_q & mask);
endmodule

// File: rtl/halt_irq_gate.sv
// Captures which requests were idle at halt entry; only those may wake.
module halt_irq_gate #(
    parameter int NIRQ = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture,
    input  logic [NIRQ-1:0] irq_req,
    input  logic [NIRQ-1:0] irq_en,
    input  logic            stack_full,
    output logic            wake,
    output logic            take_vector
);
    logic [NIRQ-1:0] armed_q;
    logic [NIRQ-1:0] live;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= '0;
        end else if (capture) begin
            armed_q <= ~irq_req;
        end
    end

    assign live        = irq_req & armed_q;
    assign wake        = |live;
    assign take_vector = (|(live & irq_en)) && !stack_full;
endmodule

// File: rtl/halt_dummy_timer.sv
// Counts the post-wake dummy period; last is high in its final cycle.
module halt_dummy_timer #(
    parameter int CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic last
);
    localparam int CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST_VAL = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = run && (cnt_q == LAST_VAL);
endmodule

// File: rtl/halt_wake_seq.sv
module halt_wake_seq
    import halt_pkg::*;
#(
    parameter int PORT_W       = 8,
    parameter int NIRQ         = 4,
    parameter int DUMMY_CYCLES = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt_req,
    input  logic [PORT_W-1:0] port_in,
    input  logic [PORT_W-1:0] port_wake_mask,
    input  logic [NIRQ-1:0]   irq_req,
    input  logic [NIRQ-1:0]   irq_en,
    input  logic              stack_full,
    input  logic              wdt_ovf,
    output logic              sys_clk_en,
    output logic              halt_out,
    output logic              halted,
    output logic              resume_pulse,
    output logic              vector_pulse,
    output logic              warm_rst_pulse
);
    seq_state_t state_q, state_d;
    wake_kind_t kind_q, kind_d;
    logic       capture, start_dummy, dummy_last;
    logic       port_fall, irq_wake, irq_vector;
    logic       resume_q, vector_q, warm_q;

    halt_port_edge #(.PORT_W(PORT_W)) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .port_in  (port_in),
        .mask     (port_wake_mask),
        .fall_any (port_fall)
    );

    halt_irq_gate #(.NIRQ(NIRQ)) u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .capture     (capture),
        .irq_req     (irq_req),
        .irq_en      (irq_en),
        .stack_full  (stack_full),
        .wake        (irq_wake),
        .take_vector (irq_vector)
    );

    halt_dummy_timer #(.CYCLES(DUMMY_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start_dummy),
        .run   (state_q == ST_DUMMY),
        .last  (dummy_last)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            kind_q  <= WK_PORT;
        end else begin
            state_q <= state_d;
            kind_q  <= kind_d;
        end
    end

    // Next state
    always_comb begin
        state_d     = state_q;
        kind_d      = kind_q;
        capture     = 1'b0;
        start_dummy = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (halt_req) begin
                    state_d = ST_HALT;
                    capture = 1'b1;
                end
            end
            ST_HALT: begin
                if (wdt_ovf) begin
                    state_d     = ST_DUMMY;
                    kind_d      = WK_WDT;
                    start_dummy = 1'b1;
                end else if (irq_wake) begin
                    state_d     = ST_DUMMY;
                    kind_d      = irq_vector ? WK_IRQ_VECTOR : WK_IRQ_RESUME;
                    start_dummy = 1'b1;
                end else if (port_fall) begin
                    state_d     = ST_DUMMY;
                    kind_d      = WK_PORT;
                    start_dummy = 1'b1;
                end
            end
            ST_DUMMY: begin
                if (dummy_last) begin
                    state_d = (kind_q == WK_IRQ_VECTOR) ? ST_ACK : ST_RUN;
                end
            end
            ST_ACK: begin
                state_d = ST_RUN;
            end
        endcase
    end

    // Outputs: registered one-cycle pulses, status decoded from state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resume_q <= 1'b0;
            vector_q <= 1'b0;
            warm_q   <= 1'b0;
        end else begin
            resume_q <= (state_q == ST_DUMMY) && dummy_last &&
                        ((kind_q == WK_PORT) || (kind_q == WK_IRQ_RESUME));
            warm_q   <= (state_q == ST_DUMMY) && dummy_last && (kind_q == WK_WDT);
            vector_q <= (state_q == ST_ACK);
        end
    end

    assign sys_clk_en     = (state_q == ST_RUN);
    assign halt_out       = (state_q == ST_HALT);
    assign halted         = (state_q != ST_RUN);
    assign resume_pulse   = resume_q;
    assign vector_pulse   = vector_q;
    assign warm_rst_pulse = warm_q;
endmodule

// File: rtl/halt_wake_seq_chk.sv
module halt_wake_seq_chk #(
    parameter int PORT_W       = 8,
    parameter int NIRQ         = 4,
    parameter int DUMMY_CYCLES = 1024
) (
    input logic              clk,
    input logic              rst_n,
    input logic              halt_req,
    input logic [PORT_W-1:0] port_in,
    input logic [PORT_W-1:0] port_wake_mask,
    input logic [NIRQ-1:0]   irq_req,
    input logic [NIRQ-1:0]   irq_en,
    input logic              stack_full,
    input logic              wdt_ovf,
    input logic              sys_clk_en,
    input logic              halt_out,
    input logic              halted,
    input logic              resume_pulse,
    input logic              vector_pulse,
    input logic              warm_rst_pulse
);
    int dcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                dcnt <= 0;
        else if (halt_out || !halted) dcnt <= 0;
        else                       dcnt <= dcnt + 1;
    end

    // R1
    halt_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && halt_req) |=> (halt_out && !sys_clk_en));

    // R4
    dummy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_pulse || warm_rst_pulse) |-> (dcnt == DUMMY_CYCLES));

    // R7
    vector_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vector_pulse |-> (dcnt == DUMMY_CYCLES + 1));

    // R9
    wdt_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_out && wdt_ovf) |=> !halt_out);

    // R12
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({resume_pulse, vector_pulse, warm_rst_pulse}) <= 1);

    // R12
    pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_pulse || vector_pulse || warm_rst_pulse) |=>
        !(resume_pulse || vector_pulse || warm_rst_pulse));
endmodule

bind halt_wake_seq halt_wake_seq_chk #(
    .PORT_W(PORT_W), .NIRQ(NIRQ), .DUMMY_CYCLES(DUMMY_CYCLES)
) u_chk (.*);

// File: tb/test_halt_wake_seq.sv
module test_halt_wake_seq;
    localparam int PW = 8;
    localparam int NI = 4;
    localparam int D  = 1024;

    // expected outcome codes
    localparam int K_NONE = 0, K_RES = 1, K_VEC = 2, K_WARM = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          halt_req = 1'b0;
    logic [PW-1:0] port_in = '0;
    logic [PW-1:0] port_wake_mask = '0;
    logic [NI-1:0] irq_req = '0;
    logic [NI-1:0] irq_en = '0;
    logic          stack_full = 1'b0;
    logic          wdt_ovf = 1'b0;
    logic          sys_clk_en, halt_out, halted;
    logic          resume_pulse, vector_pulse, warm_rst_pulse;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    halt_wake_seq #(.PORT_W(PW), .NIRQ(NI), .DUMMY_CYCLES(D)) i_halt_wake_seq (
        .clk(clk), .rst_n(rst_n), .halt_req(halt_req),
        .port_in(port_in), .port_wake_mask(port_wake_mask),
        .irq_req(irq_req), .irq_en(irq_en), .stack_full(stack_full),
        .wdt_ovf(wdt_ovf), .sys_clk_en(sys_clk_en), .halt_out(halt_out),
        .halted(halted), .resume_pulse(resume_pulse),
        .vector_pulse(vector_pulse), .warm_rst_pulse(warm_rst_pulse)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int pulses_code();
        return {29'd0, warm_rst_pulse, vector_pulse, resume_pulse};
    endfunction

    function automatic int kind_to_code(input int k);
        case (k)
            K_RES:  return 1;
            K_VEC:  return 2;
            K_WARM: return 4;
            default: return 0;
        endcase
    endfunction

    // Expected outcome from the requirements (R3, R6-R10)
    function automatic int exp_kind(input bit wdt, input logic [NI-1:0] newirq,
                                    input logic [NI-1:0] pend, input logic [NI-1:0] en,
                                    input bit sf, input logic [PW-1:0] m,
                                    input logic [PW-1:0] p0, input logic [PW-1:0] p1);
        logic [NI-1:0] live;
        live = (pend | newirq) & ~pend;
        if (wdt) return K_WARM;
        if (|live) return ((|(live & en)) && !sf) ? K_VEC : K_RES;
        if (|(p0 & ~p1 & m)) return K_RES;
        return K_NONE;
    endfunction

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic episode(input bit wdt, input logic [NI-1:0] newirq,
                           input logic [NI-1:0] pend, input logic [NI-1:0] en,
                           input bit sf, input logic [PW-1:0] m,
                           input logic [PW-1:0] p0, input logic [PW-1:0] p1);
        int k, lat, n;
        k = exp_kind(wdt, newirq, pend, en, sf, m, p0, p1);
        port_in = p0; port_wake_mask = m; irq_req = pend;
        irq_en = en; stack_full = sf; wdt_ovf = 1'b0;
        step(5);
        halt_req = 1'b1;
        step(1);
        halt_req = 1'b0;
        chk(halt_out && halted && !sys_clk_en, "R1 halt entry", int'(halt_out), 1);
        step(2);
        halt_req = 1'b1;                     // ignored while halted
        step(1);
        halt_req = 1'b0;
        step(1);
        chk(halt_out === 1'b1, (pend != 0) ? "R8 pending irq no wake" : "R2 stays halted",
            int'(halt_out), 1);
        port_in = p1;
        irq_req = pend | newirq;
        wdt_ovf = wdt;
        if (k == K_NONE) begin
            step(8);
            chk(halt_out === 1'b1, "R3 no wake on rising/unmasked edge", int'(halt_out), 1);
            wdt_ovf = 1'b1;
            k = K_WARM;
            lat = 1;
        end else begin
            lat = (wdt || (k == K_VEC) || (|((pend | newirq) & ~pend))) ? 1 : 3;
        end
        n = 0;
        while (halt_out && n < 10) begin
            step(1);
            n++;
        end
        chk(n == lat, (lat == 3) ? "R3 port wake latency" : "R10 wake latency", n, lat);
        wdt_ovf = 1'b0;
        irq_req = '0;
        n = 0;
        while (halted && n < D + 10) begin
            chk(!sys_clk_en && pulses_code() == 0 || n > 0 && !sys_clk_en, "R4 gated", int'(sys_clk_en), 0);
            checks--;                         // gating counted once below
            step(1);
            n++;
        end
        chk(n == ((k == K_VEC) ? D + 1 : D), "R4 dummy length", n, (k == K_VEC) ? D + 1 : D);
        chk(pulses_code() == kind_to_code(k) && sys_clk_en,
            (k == K_VEC) ? "R7 vector pulse" : (k == K_WARM) ? "R9 warm pulse" : "R5 R6 resume pulse",
            pulses_code(), kind_to_code(k));
        step(1);
        chk(pulses_code() == 0, "R12 one-cycle pulse", pulses_code(), 0);
    endtask

    initial begin
        void'($urandom(32'h1A2B3C4D));
        step(1);
        chk(sys_clk_en && !halted && !halt_out && pulses_code() == 0,
            "R11 reset state", int'(halted), 0);
        rst_n = 1'b1;
        step(2);

        // Directed corners
        episode(0, '0, '0, '0, 0, 8'h10, 8'hFF, 8'hEF);          // R3 R5 masked fall
        episode(0, '0, '0, '0, 0, 8'h0F, 8'hF0, 8'h00);          // R3 unmasked fall: none
        episode(0, '0, '0, '0, 0, 8'hFF, 8'h00, 8'hFF);          // R3 rising only: none
        episode(0, 4'b0010, '0, 4'b0000, 0, 8'h00, 8'h00, 8'h00); // R6 disabled
        episode(0, 4'b0010, '0, 4'b0010, 1, 8'h00, 8'h00, 8'h00); // R6 stack full
        episode(0, 4'b0100, '0, 4'b0100, 0, 8'h00, 8'h00, 8'h00); // R7 vector
        episode(0, 4'b0001, 4'b0001, 4'b1111, 0, 8'h00, 8'h00, 8'h00); // R8 pending only
        episode(0, 4'b1000, 4'b0001, 4'b1000, 0, 8'h00, 8'h00, 8'h00); // R8 other bit wakes
        episode(1, 4'b0100, '0, 4'b0100, 0, 8'hFF, 8'hFF, 8'h00); // R10 wdt first
        episode(0, 4'b0100, '0, 4'b0000, 0, 8'hFF, 8'hFF, 8'h00); // R10 irq over port

        // Constrained random
        for (int e = 0; e < 14; e++) begin
            logic [NI-1:0] pnd;
            pnd = NI'($urandom) & NI'($urandom);
            episode(($urandom % 5) == 0, NI'($urandom), pnd, NI'($urandom),
                    ($urandom % 3) == 0, PW'($urandom), PW'($urandom), PW'($urandom));
        end

        // R11: external reset during the dummy period
        halt_req = 1'b1; step(1); halt_req = 1'b0;
        wdt_ovf = 1'b1; step(2); wdt_ovf = 1'b0;
        step(20);
        rst_n = 1'b0;
        #1;
        chk(sys_clk_en && !halted && !halt_out && pulses_code() == 0,
            "R11 async reset", int'(halted), 0);
        step(1);
        rst_n = 1'b1;
        begin
            int seen;
            seen = 0;
            for (int i = 0; i < D + 8; i++) begin
                step(1);
                if (pulses_code() != 0 || halted) seen++;
            end
            chk(seen == 0, "R11 no pulse after reset", seen, 0);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule